// File: doc/BRIEF.md
# Variable Pulse Width Symbol Decoder

This block turns a single-wire variable-pulse-width bus line into a stream of decoded events. It times the gap between consecutive line transitions in whole microseconds and sorts each gap into one of these classes: frame start, short symbol, long symbol, glitch or invalid interval. A quiet line inside a frame is also detected and reported as frame end. The bit value of a data symbol depends on two things: its width and the line level held during it.

The block waits in a hunting state until it sees a frame start. The width of that start pulse chooses normal or quadruple bit rate, and all later symbol windows and the frame-end timeout are scaled down by the fast-rate divisor. Each event leaves the block as a one-cycle registered strobe. A downstream byte assembler or frame parser consumes these strobes directly.

Top module: `vpw_rx_decoder`

## Requirements
- R1: A synchronous active-high `rst` forces all strobes low and returns the block to hunting. Transitions that follow a reset taken mid-frame decode nothing until a new frame start arrives.
- R2: While hunting, a low-level (active) interval of 164 to 244 µs inclusive produces `sof_stb` with `sof_fast` = 0, and the block enters the frame.
- R3: While hunting, a low-level interval of 41 to 60 µs inclusive produces `sof_stb` with `sof_fast` = 1. Any other width, and any high-level (passive) interval, produces no strobe.
- R4: Inside a frame, a short symbol is 24 to 96 µs at normal rate or 6 to 23 µs at fast rate. It decodes as `bit_val` = 1 when the line was low and 0 when it was high.
- R5: Inside a frame, a long symbol is 97 to 169 µs at normal rate or 24 to 41 µs at fast rate. It decodes as `bit_val` = 0 when the line was low and 1 when it was high.
- R6: Inside a frame, no transition for 240 µs (60 µs at fast rate) produces one `eof_stb` and a return to hunting. No `eof_stb` appears before that time.
- R7: Inside a frame, an interval of at most 2 µs that fits no symbol window produces no strobe. The next interval is timed from the glitch's closing transition.
- R8: Inside a frame, any other interval that fits no window produces `err_stb` and a return to hunting. No `eof_stb` follows.
- R9: The microsecond interval counter saturates at its maximum value. A low interval longer than the counter range can never alias into a frame-start width.
- R10: No more than one of the four strobes is high in any cycle, and no strobe is high for two consecutive cycles.
- R11: The strobe for an interval rises on the third rising clock edge after the closing transition on `line_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, frequency set by `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Asynchronous bus line, low is the active level |
| sof_stb | output | 1 | One-cycle frame start strobe |
| sof_fast | output | 1 | Rate of the last frame start, 1 = quadruple |
| bit_stb | output | 1 | One-cycle data symbol strobe |
| bit_val | output | 1 | Decoded value, valid with `bit_stb` |
| eof_stb | output | 1 | One-cycle frame end strobe (line idle timeout) |
| err_stb | output | 1 | One-cycle invalid interval strobe |

## Verification
The bench builds the decoder with `CLK_HZ` = 4 MHz, so one microsecond is four clocks. Every window edge (24/96/97/169/170 µs, 5/6/23/24/41/42 µs, and the start-width edges) then falls on an exact clock count, and full-length frames fit comfortably in the run. The counter width keeps its default of 9 bits. This makes a 712 µs low pulse usable as the saturation test: a wrapping counter would read it as a 200 µs frame start.

// File: rtl/vpw_rx_pkg.sv
`timescale 1ns/1ps
package vpw_rx_pkg;

  // Classification of one measured interval
  typedef enum logic [2:0] {
    SYM_NONE,
    SYM_SOF_SLOW,
    SYM_SOF_FAST,
    SYM_ZERO,
    SYM_ONE,
    SYM_GLITCH,
    SYM_BAD
  } vpw_sym_e;

  typedef enum logic {
    ST_HUNT,
    ST_FRAME
  } vpw_state_e;

  // Index of a rate bank: 0 = normal, 1 = quadruple
  localparam int RATE_BANKS = 2;

endpackage

// File: rtl/vpw_line_sync.sv
`timescale 1ns/1ps
module vpw_line_sync #(
  parameter int   STAGES     = 2,
  parameter logic ACTIVE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_edge,
  output logic ended_active
);

  localparam logic IDLE_LVL = ~ACTIVE_LVL;

  logic [STAGES-1:0] stage_q;
  logic              last_q;

  // Metastability chain followed by one history flop for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {STAGES{IDLE_LVL}};
      last_q  <= IDLE_LVL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        stage_q[i] <= stage_q[i-1];
      end
      stage_q[0] <= line_in;
      last_q     <= stage_q[STAGES-1];
    end
  end

  assign line_edge    = stage_q[STAGES-1] ^ last_q;
  // Level held during the interval that this edge closes
  assign ended_active = (last_q == ACTIVE_LVL);

endmodule

// File: rtl/vpw_us_timer.sv
`timescale 1ns/1ps
module vpw_us_timer #(
  parameter int CYC_PER_US = 48,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] us_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  generate
    if (CYC_PER_US <= 1) begin : g_direct
      // One clock per microsecond: the restart cycle itself counts as one
      always_ff @(posedge clk) begin
        if (rst) begin
          us_cnt <= '0;
        end else if (restart) begin
          us_cnt <= CNT_W'(1);
        end else if (us_cnt != CNT_MAX) begin
          us_cnt <= us_cnt + CNT_W'(1);
        end
      end
    end else begin : g_prescaled
      localparam int              PRE_W    = (CYC_PER_US > 2) ? $clog2(CYC_PER_US) : 1;
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

      logic [PRE_W-1:0] pre_q;
      logic             tick;

      assign tick = (pre_q == PRE_LAST) && !restart;

      // Restart loads 1 so the edge cycle counts as elapsed time:
      // the value at the next edge is floor(clocks / CYC_PER_US)
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
        end else if (restart) begin
          pre_q <= PRE_W'(1);
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          us_cnt <= '0;
        end else if (restart) begin
          us_cnt <= '0;
        end else if (tick && (us_cnt != CNT_MAX)) begin
          us_cnt <= us_cnt + CNT_W'(1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vpw_sym_class.sv
`timescale 1ns/1ps
module vpw_sym_class
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int SOF_LO_US   = 164,
  parameter int SOF_HI_US   = 245,
  parameter int SHORT_LO_US = 24,
  parameter int SPLIT_US    = 97,
  parameter int LONG_HI_US  = 170,
  parameter int GLITCH_US   = 2,
  parameter int FAST_DIV    = 4
) (
  input  logic [CNT_W-1:0] interval,
  input  logic             hunting,
  input  logic             fast,
  input  logic             was_active,
  output vpw_sym_e         sym
);

  logic [RATE_BANKS-1:0] sof_hit;
  logic [RATE_BANKS-1:0] short_hit;
  logic [RATE_BANKS-1:0] long_hit;

  // One window bank per rate; the fast bank divides every bound
  for (genvar r = 0; r < RATE_BANKS; r++) begin : g_rate
    localparam int DIV = (r == 0) ? 1 : FAST_DIV;
    localparam logic [CNT_W-1:0] SOF_LO = CNT_W'(SOF_LO_US / DIV);
    localparam logic [CNT_W-1:0] SOF_HI = CNT_W'(SOF_HI_US / DIV);
    localparam logic [CNT_W-1:0] SH_LO  = CNT_W'(SHORT_LO_US / DIV);
    localparam logic [CNT_W-1:0] SPLIT  = CNT_W'(SPLIT_US / DIV);
    localparam logic [CNT_W-1:0] LG_HI  = CNT_W'(LONG_HI_US / DIV);

    assign sof_hit[r]   = (interval >= SOF_LO) && (interval < SOF_HI);
    assign short_hit[r] = (interval >= SH_LO)  && (interval < SPLIT);
    assign long_hit[r]  = (interval >= SPLIT)  && (interval < LG_HI);
  end

  always_comb begin
    sym = SYM_NONE;
    if (hunting) begin
      if (was_active) begin
        if (sof_hit[0]) begin
          sym = SYM_SOF_SLOW;
        end else if (sof_hit[1]) begin
          sym = SYM_SOF_FAST;
        end
      end
    end else begin
      if (short_hit[fast]) begin
        sym = was_active ? SYM_ONE : SYM_ZERO;
      end else if (long_hit[fast]) begin
        sym = was_active ? SYM_ZERO : SYM_ONE;
      end else if (interval <= CNT_W'(GLITCH_US)) begin
        sym = SYM_GLITCH;
      end else begin
        sym = SYM_BAD;
      end
    end
  end

endmodule

// File: rtl/vpw_rx_decoder.sv
`timescale 1ns/1ps
module vpw_rx_decoder
  import vpw_rx_pkg::*;
#(
  parameter int   CLK_HZ      = 48_000_000,
  parameter int   CNT_W       = 9,
  parameter int   SYNC_STAGES = 2,
  parameter logic ACTIVE_LVL  = 1'b0,
  parameter int   SOF_LO_US   = 164,
  parameter int   SOF_HI_US   = 245,
  parameter int   SHORT_LO_US = 24,
  parameter int   SPLIT_US    = 97,
  parameter int   LONG_HI_US  = 170,
  parameter int   GLITCH_US   = 2,
  parameter int   EOF_US      = 240,
  parameter int   FAST_DIV    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic sof_stb,
  output logic sof_fast,
  output logic bit_stb,
  output logic bit_val,
  output logic eof_stb,
  output logic err_stb
);

  localparam int               CYC_PER_US = CLK_HZ / 1_000_000;
  localparam logic [CNT_W-1:0] EOF_SLOW   = CNT_W'(EOF_US);
  localparam logic [CNT_W-1:0] EOF_FAST   = CNT_W'(EOF_US / FAST_DIV);

  logic             line_edge;
  logic             ended_active;
  logic [CNT_W-1:0] us_cnt;
  vpw_sym_e         sym;
  vpw_state_e       state_q;
  logic             fast_q;
  logic             in_frame;
  logic [CNT_W-1:0] eof_lim;
  logic             idle_timeout;

  assign in_frame     = (state_q == ST_FRAME);
  assign eof_lim      = fast_q ? EOF_FAST : EOF_SLOW;
  assign idle_timeout = in_frame && !line_edge && (us_cnt >= eof_lim);

  vpw_line_sync #(
    .STAGES     (SYNC_STAGES),
    .ACTIVE_LVL (ACTIVE_LVL)
  ) u_sync (
    .clk          (clk),
    .rst          (rst),
    .line_in      (line_in),
    .line_edge    (line_edge),
    .ended_active (ended_active)
  );

  vpw_us_timer #(
    .CYC_PER_US (CYC_PER_US),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (line_edge),
    .us_cnt  (us_cnt)
  );

  vpw_sym_class #(
    .CNT_W       (CNT_W),
    .SOF_LO_US   (SOF_LO_US),
    .SOF_HI_US   (SOF_HI_US),
    .SHORT_LO_US (SHORT_LO_US),
    .SPLIT_US    (SPLIT_US),
    .LONG_HI_US  (LONG_HI_US),
    .GLITCH_US   (GLITCH_US),
    .FAST_DIV    (FAST_DIV)
  ) u_class (
    .interval   (us_cnt),
    .hunting    (!in_frame),
    .fast       (fast_q),
    .was_active (ended_active),
    .sym        (sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_HUNT;
      fast_q   <= 1'b0;
      sof_stb  <= 1'b0;
      sof_fast <= 1'b0;
      bit_stb  <= 1'b0;
      bit_val  <= 1'b0;
      eof_stb  <= 1'b0;
      err_stb  <= 1'b0;
    end else begin
      sof_stb <= 1'b0;
      bit_stb <= 1'b0;
      eof_stb <= 1'b0;
      err_stb <= 1'b0;
      case (state_q)
        ST_HUNT: begin
          if (line_edge && ((sym == SYM_SOF_SLOW) || (sym == SYM_SOF_FAST))) begin
            state_q  <= ST_FRAME;
            fast_q   <= (sym == SYM_SOF_FAST);
            sof_fast <= (sym == SYM_SOF_FAST);
            sof_stb  <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (line_edge) begin
            case (sym)
              SYM_ZERO, SYM_ONE: begin
                bit_stb <= 1'b1;
                bit_val <= (sym == SYM_ONE);
              end
              SYM_GLITCH: begin
              end
              default: begin
                err_stb <= 1'b1;
                state_q <= ST_HUNT;
              end
            endcase
          end else if (idle_timeout) begin
            eof_stb <= 1'b1;
            state_q <= ST_HUNT;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/vpw_rx_decoder_chk.sv
`timescale 1ns/1ps
module vpw_rx_decoder_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             sof_stb,
  input logic             bit_stb,
  input logic             eof_stb,
  input logic             err_stb,
  input logic             in_frame,
  input logic             restart,
  input logic [CNT_W-1:0] us_cnt
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(sof_stb || bit_stb || eof_stb || err_stb));

  p_sof_enters_frame_r2: assert property (@(posedge clk) disable iff (rst)
    sof_stb |-> (in_frame && !$past(in_frame)));

  p_bit_inside_frame_r4: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> (in_frame && $past(in_frame)));

  p_eof_leaves_frame_r6: assert property (@(posedge clk) disable iff (rst)
    eof_stb |-> (!in_frame && $past(in_frame)));

  p_err_leaves_frame_r8: assert property (@(posedge clk) disable iff (rst)
    err_stb |-> (!in_frame && $past(in_frame)));

  p_counter_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (($past(us_cnt) == {CNT_W{1'b1}}) && !$past(restart)) |-> (us_cnt == {CNT_W{1'b1}}));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sof_stb, bit_stb, eof_stb, err_stb}));

  p_bit_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  p_sof_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sof_stb |=> !sof_stb);

endmodule

bind vpw_rx_decoder vpw_rx_decoder_chk #(
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sof_stb  (sof_stb),
  .bit_stb  (bit_stb),
  .eof_stb  (eof_stb),
  .err_stb  (err_stb),
  .in_frame (in_frame),
  .restart  (line_edge),
  .us_cnt   (us_cnt)
);

// File: tb/vpw_rx_decoder_tb.sv
`timescale 1ns/1ps
module vpw_rx_decoder_tb;

  localparam int TB_CLK_HZ  = 4_000_000;
  localparam int CPU        = TB_CLK_HZ / 1_000_000;
  localparam int WD_CYCLES  = 195_000;
  localparam int NV         = 29;

  // Entry: {start width us, level (0 low/active, 1 high/passive), test width us, outcome}
  // Outcome: 0 bit 0, 1 bit 1, 2 glitch, 3 error, 4 no frame start
  localparam logic [19:0] VEC [NV] = '{
    {8'd200, 1'b0, 8'd64,  3'd1}, {8'd200, 1'b0, 8'd24,  3'd1},
    {8'd200, 1'b0, 8'd96,  3'd1}, {8'd200, 1'b0, 8'd97,  3'd0},
    {8'd200, 1'b0, 8'd169, 3'd0}, {8'd200, 1'b1, 8'd64,  3'd0},
    {8'd200, 1'b1, 8'd128, 3'd1}, {8'd200, 1'b0, 8'd170, 3'd3},
    {8'd200, 1'b0, 8'd23,  3'd3}, {8'd200, 1'b0, 8'd2,   3'd2},
    {8'd200, 1'b1, 8'd3,   3'd3},
    {8'd50,  1'b0, 8'd16,  3'd1}, {8'd50,  1'b0, 8'd6,   3'd1},
    {8'd50,  1'b0, 8'd23,  3'd1}, {8'd50,  1'b0, 8'd24,  3'd0},
    {8'd50,  1'b0, 8'd41,  3'd0}, {8'd50,  1'b1, 8'd16,  3'd0},
    {8'd50,  1'b1, 8'd32,  3'd1}, {8'd50,  1'b0, 8'd42,  3'd3},
    {8'd50,  1'b0, 8'd5,   3'd3}, {8'd50,  1'b0, 8'd2,   3'd2},
    {8'd164, 1'b0, 8'd64,  3'd1}, {8'd244, 1'b0, 8'd64,  3'd1},
    {8'd245, 1'b0, 8'd64,  3'd4}, {8'd163, 1'b0, 8'd64,  3'd4},
    {8'd41,  1'b0, 8'd16,  3'd1}, {8'd60,  1'b0, 8'd16,  3'd1},
    {8'd61,  1'b0, 8'd16,  3'd4}, {8'd40,  1'b0, 8'd16,  3'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b1;
  logic sof_stb, sof_fast, bit_stb, bit_val, eof_stb, err_stb;

  int n_checks = 0;
  int n_fail   = 0;
  int c_sof = 0, c_bit = 0, c_eof = 0, c_err = 0, c_multi = 0;
  logic        last_fast = 1'b0;
  logic        prev_any  = 1'b0;
  logic [31:0] hist      = '0;
  bit          done      = 1'b0;

  always #2.5 clk = ~clk;

  vpw_rx_decoder #(
    .CLK_HZ (TB_CLK_HZ)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .line_in  (line),
    .sof_stb  (sof_stb),
    .sof_fast (sof_fast),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .eof_stb  (eof_stb),
    .err_stb  (err_stb)
  );

  // Event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sof_stb) begin
      c_sof     <= c_sof + 1;
      last_fast <= sof_fast;
    end
    if (bit_stb) begin
      c_bit <= c_bit + 1;
      hist  <= {hist[30:0], bit_val};
    end
    if (eof_stb) c_eof <= c_eof + 1;
    if (err_stb) c_err <= c_err + 1;
    // R10: more than one strobe, or a strobe held over two cycles
    if ($countones({sof_stb, bit_stb, eof_stb, err_stb}) > 1 ||
        (prev_any && (sof_stb || bit_stb || eof_stb || err_stb)))
      c_multi <= c_multi + 1;
    prev_any <= sof_stb || bit_stb || eof_stb || err_stb;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic hold(input logic lv, input int us);
    line = lv;
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=completion", WD_CYCLES);
      finish_run();
    end
  end

  initial begin : main
    int s_sof, s_bit, s_eof, s_err;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!(sof_stb | bit_stb | eof_stb | err_stb | sof_fast | bit_val), "R1",
          int'({sof_stb, sof_fast, bit_stb, bit_val, eof_stb, err_stb}), 0);

    // R11 / R2: strobe latency for a 200 us start pulse
    hold(1'b1, 30);
    hold(1'b0, 200);
    line = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sof_stb == 1'b0, "R11", int'(sof_stb), 0);
    @(negedge clk);
    check(sof_stb == 1'b1, "R11", int'(sof_stb), 1);
    check(sof_fast == 1'b0, "R2", int'(sof_fast), 0);

    // R6: frame end timing, 240 us after the last transition
    s_eof = c_eof;
    repeat (952) @(negedge clk);
    check(c_eof == s_eof, "R6", c_eof - s_eof, 0);
    repeat (15) @(negedge clk);
    check(c_eof == s_eof + 1, "R6", c_eof - s_eof, 1);

    // R1: reset taken inside a frame drops the frame
    hold(1'b1, 30);
    hold(1'b0, 200);
    hold(1'b1, 20);
    s_bit = c_bit; s_eof = c_eof;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!(sof_stb | bit_stb | eof_stb | err_stb), "R1",
          int'({sof_stb, bit_stb, eof_stb, err_stb}), 0);
    rst = 1'b0;
    hold(1'b1, 44);
    hold(1'b0, 64);
    hold(1'b1, 300);
    check((c_bit == s_bit) && (c_eof == s_eof), "R1",
          (c_bit - s_bit) + (c_eof - s_eof), 0);

    // R9: a 712 us low pulse would read as 200 us on a wrapping 9-bit counter
    s_sof = c_sof;
    hold(1'b1, 30);
    hold(1'b0, 712);
    hold(1'b1, 300);
    check(c_sof == s_sof, "R9", c_sof - s_sof, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] sw;
      logic [7:0] w;
      logic       pas;
      logic [2:0] ex;
      bit         fast;
      int         dv;
      int         exp_n;
      string      tg;

      {sw, pas, w, ex} = VEC[i];
      fast  = (sw < 8'd100);
      dv    = fast ? 4 : 1;
      exp_n = (ex == 3'd4) ? 0 : ((pas ? 0 : 1) + ((ex < 3'd2) ? 1 : 0));
      if (ex == 3'd4)               tg = "R3";
      else if (ex == 3'd3)          tg = "R8";
      else if (ex == 3'd2)          tg = "R7";
      else if (int'(w) >= 97 / dv)  tg = "R5";
      else                          tg = "R4";

      s_sof = c_sof; s_bit = c_bit; s_eof = c_eof; s_err = c_err;
      hold(1'b1, 30);
      hold(1'b0, int'(sw));
      if (pas) begin
        hold(1'b1, int'(w));
        hold(1'b0, 260 / dv);
      end else begin
        hold(1'b1, 64 / dv);
        hold(1'b0, int'(w));
        hold(1'b1, 260 / dv);
      end
      repeat (8) @(negedge clk);

      if (ex == 3'd4) begin
        check((c_sof == s_sof) && (c_bit == s_bit) && (c_eof == s_eof) && (c_err == s_err),
              "R3", (c_sof - s_sof) + (c_bit - s_bit) + (c_eof - s_eof) + (c_err - s_err), 0);
      end else begin
        check(c_sof == s_sof + 1, fast ? "R3" : "R2", c_sof - s_sof, 1);
        check(last_fast == fast, fast ? "R3" : "R2", int'(last_fast), int'(fast));
        check(c_bit - s_bit == exp_n, tg, c_bit - s_bit, exp_n);
        if (exp_n == 2)
          check(hist[1:0] == {1'b0, ex[0]}, tg, int'(hist[1:0]), int'({1'b0, ex[0]}));
        else if (exp_n == 1)
          check(hist[0] == (pas ? ex[0] : 1'b0), tg, int'(hist[0]), int'(pas ? ex[0] : 1'b0));
        check(c_eof - s_eof == ((ex == 3'd3) ? 0 : 1), (ex == 3'd3) ? "R8" : "R6",
              c_eof - s_eof, (ex == 3'd3) ? 0 : 1);
        check(c_err - s_err == ((ex == 3'd3) ? 1 : 0), "R8",
              c_err - s_err, (ex == 3'd3) ? 1 : 0);
      end
    end

    // R10: strobes stayed single-cycle and exclusive throughout
    check(c_multi == 0, "R10", c_multi, 0);

    done = 1'b1;
    finish_run();
  end

endmodule